// File: doc/BRIEF.md
# Signed Fixed-Point Rounding and Range-Reduction Unit

This unit narrows a two's-complement word in two steps. First it discards `N` fractional low bits, rounding by one of eight rules chosen per sample through a 3-bit code. Then it discards `M` high integer bits. That second step either clamps to the representable range or simply wraps, chosen per sample by `sat_en`. The result is `W-N-M` bits wide and is registered once. An overflow flag reports any sample whose rounded value did not fit the output range.

Rounding is carried one bit wider than the truncated quotient. A carry out of the top during rounding therefore reaches the range step as an ordinary out-of-range value and is never lost. A build-time option, `SYM_CLAMP`, narrows the negative bound to the negation of the positive bound. Typical uses are scaling a DSP accumulator down to a datapath width, or requantising a filter output before storage.

Top module: `fxr_unit`

## Requirements
- R1: Mode code 0 rounds toward minus infinity: the result is the largest integer not above the scaled input (input / 2^N).
- R2: Mode code 1 rounds toward plus infinity: the result is the smallest integer not below the scaled input.
- R3: Mode code 2 rounds to nearest, and exact halves go up: floor(v + 0.5).
- R4: Mode code 3 rounds to nearest, and exact halves go down: ceil(v - 0.5).
- R5: Mode code 4 rounds to nearest, and exact halves go away from zero.
- R6: Mode code 5 rounds to nearest, and exact halves go toward zero.
- R7: Mode code 6 rounds to nearest, and exact halves go to the even neighbour.
- R8: Mode code 7 rounds to nearest, and exact halves go to the odd neighbour.
- R9: With `sat_en`=1, a rounded value above the positive bound 2^(OW-1)-1 gives that bound. A value below the negative bound gives the negative bound. In both cases `out_ovf`=1.
- R10: With `sat_en`=0, the output is the low OW bits of the rounded value, so the result wraps. `out_ovf` still flags an out-of-range value.
- R11: With `SYM_CLAMP`=1, the negative bound is -(2^(OW-1)-1). A rounded value of -2^(OW-1) therefore counts as out of range: it is clamped when saturating and kept as is (wrapped) when not, with `out_ovf`=1 in both cases.
- R12: `out_valid` rises exactly one cycle after a cycle with `in_valid`=1 and is low otherwise. Reset clears `out_valid`, `out_data` and `out_ovf`.
- R13: A cycle with `in_valid`=0 leaves `out_data` and `out_ovf` unchanged, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | W | Two's-complement input sample |
| round_mode | input | 3 | Rounding rule code, 0..7 |
| sat_en | input | 1 | 1 = clamp, 0 = wrap |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | W-N-M | Rounded, range-reduced result |
| out_ovf | output | 1 | Rounded value was outside the output range |

## Verification
The bench runs every input value of a reduced configuration through all eight codes, both with and without clamping, and it drives a symmetric-clamp instance in parallel. This catches a tie rule that breaks the wrong way on negative inputs. Such an error shows up as -1.5 mapping to -1 where -2 is due, or the reverse. A value just below the top that rounds up past it is a separate target. A design that drops the extra carry bit returns a large negative number instead of the positive bound. For the most negative representable result, a design that ignores the symmetric option would pass it through unflagged. A design that registers regardless of the strobe would change its output during idle cycles, and the hold check after a single sample catches that.

// File: rtl/fxr_pkg.sv
package fxr_pkg;

   // code order matters: it is the software-visible mode encoding
   typedef enum logic [2:0] {
      RND_FLOOR     = 3'd0,
      RND_CEIL      = 3'd1,
      RND_HALF_UP   = 3'd2,
      RND_HALF_DOWN = 3'd3,
      RND_HALF_AWAY = 3'd4,
      RND_HALF_ZERO = 3'd5,
      RND_HALF_EVEN = 3'd6,
      RND_HALF_ODD  = 3'd7
   } rnd_mode_e;

endpackage

// File: rtl/fxr_round.sv
module fxr_round
   import fxr_pkg::*;
#(
   parameter int W = 16,
   parameter int N = 4
) (
   input  logic [W-1:0]   din,
   input  rnd_mode_e      mode,
   output logic [W-N:0]   rnd
);
   localparam int QW = W - N;
   localparam int RW = QW + 1;

   logic [QW-1:0] quo;
   logic          half_bit;
   logic          below_any;
   logic          tie;
   logic          above;
   logic          frac_any;
   logic          neg;
   logic          inc;

   assign quo      = din[W-1:N];
   assign half_bit = din[N-1];
   assign neg      = din[W-1];

   generate
      if (N == 1) begin : g_single
         assign below_any = 1'b0;
      end else begin : g_multi
         assign below_any = |din[N-2:0];
      end
   endgenerate

   assign frac_any = half_bit | below_any;
   assign tie      = half_bit & ~below_any;
   assign above    = half_bit & below_any;

   always_comb begin
      unique case (mode)
         RND_FLOOR:     inc = 1'b0;
         RND_CEIL:      inc = frac_any;
         RND_HALF_UP:   inc = half_bit;
         RND_HALF_DOWN: inc = above;
         RND_HALF_AWAY: inc = above | (tie & ~neg);
         RND_HALF_ZERO: inc = above | (tie & neg);
         RND_HALF_EVEN: inc = above | (tie & quo[0]);
         RND_HALF_ODD:  inc = above | (tie & ~quo[0]);
         default:       inc = 1'b0;
      endcase
   end

   assign rnd = {quo[QW-1], quo} + {{(RW-1){1'b0}}, inc};

endmodule

// File: rtl/fxr_clamp.sv
module fxr_clamp #(
   parameter int RW  = 13,
   parameter int OW  = 8,
   parameter bit SYM = 1'b0
) (
   input  logic [RW-1:0] val,
   input  logic          sat_en,
   output logic [OW-1:0] res,
   output logic          ovf
);
   localparam int DW = RW - OW + 1;
   localparam logic [OW-1:0] POS_MAX = {1'b0, {(OW-1){1'b1}}};
   localparam logic [OW-1:0] NEG_MIN = {1'b1, {(OW-1){1'b0}}};
   localparam logic [OW-1:0] NEG_SYM = NEG_MIN | {{(OW-1){1'b0}}, 1'b1};

   logic [DW-1:0] head;
   logic          out_of_range;
   logic          sym_hit;
   logic [OW-1:0] lo_bound;

   assign head         = val[RW-1:OW-1];
   assign out_of_range = ~((&head) | ~(|head));

   generate
      if (SYM) begin : g_sym
         assign sym_hit  = ~out_of_range & (val[OW-1:0] == NEG_MIN);
         assign lo_bound = NEG_SYM;
      end else begin : g_plain
         assign sym_hit  = 1'b0;
         assign lo_bound = NEG_MIN;
      end
   endgenerate

   assign ovf = out_of_range | sym_hit;

   always_comb begin
      if (sat_en && ovf)
         res = val[RW-1] ? lo_bound : POS_MAX;
      else
         res = val[OW-1:0];
   end

endmodule

// File: rtl/fxr_unit.sv
module fxr_unit
   import fxr_pkg::*;
#(
   parameter int W         = 16,
   parameter int N         = 4,
   parameter int M         = 4,
   parameter bit SYM_CLAMP = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [W-1:0]     in_data,
   input  logic [2:0]       round_mode,
   input  logic             sat_en,
   output logic             out_valid,
   output logic [W-N-M-1:0] out_data,
   output logic             out_ovf
);
   localparam int OW = W - N - M;
   localparam int RW = W - N + 1;

   generate
      if (N < 1)  begin : g_bad_n  $error("fxr_unit: N must be at least 1");  end
      if (M < 0)  begin : g_bad_m  $error("fxr_unit: M must not be negative"); end
      if (OW < 2) begin : g_bad_ow $error("fxr_unit: output must keep 2 bits"); end
   endgenerate

   logic [RW-1:0] rnd_val;
   logic [OW-1:0] nxt_data;
   logic          nxt_ovf;

   fxr_round #(.W(W), .N(N)) u_round (
      .din  (in_data),
      .mode (rnd_mode_e'(round_mode)),
      .rnd  (rnd_val)
   );

   fxr_clamp #(.RW(RW), .OW(OW), .SYM(SYM_CLAMP)) u_clamp (
      .val    (rnd_val),
      .sat_en (sat_en),
      .res    (nxt_data),
      .ovf    (nxt_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_ovf   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= nxt_data;
            out_ovf  <= nxt_ovf;
         end
      end
   end

endmodule

// File: rtl/fxr_unit_chk.sv
module fxr_unit_chk #(
   parameter int OW  = 8,
   parameter bit SYM = 1'b0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          sat_en,
   input logic          out_valid,
   input logic [OW-1:0] out_data,
   input logic          out_ovf
);
   localparam logic [OW-1:0] POS_MAX = {1'b0, {(OW-1){1'b1}}};
   localparam logic [OW-1:0] NEG_MIN = {1'b1, {(OW-1){1'b0}}};
   localparam logic [OW-1:0] LO_BND  = SYM ? (NEG_MIN | {{(OW-1){1'b0}}, 1'b1}) : NEG_MIN;

   assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_data) && $stable(out_ovf)));

   assert_clamp_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sat_en) |=> (!out_ovf || out_data == POS_MAX || out_data == LO_BND));

   generate
      if (SYM) begin : g_sym_chk
         assert_sym_floor_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && sat_en) |=> (out_data != NEG_MIN));
      end
   endgenerate

endmodule

bind fxr_unit fxr_unit_chk #(.OW(OW), .SYM(SYM_CLAMP)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .sat_en    (sat_en),
   .out_valid (out_valid),
   .out_data  (out_data),
   .out_ovf   (out_ovf)
);

// File: tb/fxr_unit_test.sv
module fxr_unit_test;
   localparam int TW  = 10;
   localparam int TN  = 3;
   localparam int TM  = 2;
   localparam int TOW = TW - TN - TM;
   localparam int OMASK = (1 << TOW) - 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [TW-1:0]   in_data = '0;
   logic [2:0]      round_mode = 3'd0;
   logic            sat_en = 1'b0;
   logic            out_valid, out_valid_s;
   logic [TOW-1:0]  out_data, out_data_s;
   logic            out_ovf, out_ovf_s;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   fxr_unit #(.W(TW), .N(TN), .M(TM), .SYM_CLAMP(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .round_mode(round_mode), .sat_en(sat_en),
      .out_valid(out_valid), .out_data(out_data), .out_ovf(out_ovf));

   fxr_unit #(.W(TW), .N(TN), .M(TM), .SYM_CLAMP(1'b1)) uut_sym (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .round_mode(round_mode), .sat_en(sat_en),
      .out_valid(out_valid_s), .out_data(out_data_s), .out_ovf(out_ovf_s));

   task automatic chk(string tag, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic string mode_tag(int m);
      case (m)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return "R5";
         5: return "R6";
         6: return "R7";
         default: return "R8";
      endcase
   endfunction

   // independent model from the requirement text
   function automatic void ref_model(int x, int mode, bit sat, bit sym,
                                     output int res, output bit ov);
      int fl, fr, h, r, mx, lo;
      bit gt, eq, nz, odd, inc;
      fl  = x >>> TN;
      fr  = x & ((1 << TN) - 1);
      h   = 1 << (TN - 1);
      gt  = fr > h;
      eq  = fr == h;
      nz  = fr != 0;
      odd = (fl & 1) != 0;
      case (mode)
         0: inc = 1'b0;
         1: inc = nz;
         2: inc = fr >= h;
         3: inc = gt;
         4: inc = gt | (eq & (x >= 0));
         5: inc = gt | (eq & (x < 0));
         6: inc = gt | (eq & odd);
         default: inc = gt | (eq & !odd);
      endcase
      r  = fl + int'(inc);
      mx = (1 << (TOW - 1)) - 1;
      lo = sym ? -mx : -mx - 1;
      ov = (r > mx) || (r < lo);
      if (sat && ov) res = (r > mx) ? mx : lo;
      else           res = r;
      res = res & OMASK;
   endfunction

   task automatic step(int x, int mode, bit sat);
      @(negedge clk);
      in_valid   = 1'b1;
      in_data    = x[TW-1:0];
      round_mode = mode[2:0];
      sat_en     = sat;
      @(negedge clk);
      in_valid   = 1'b0;
   endtask

   task automatic test_reset;
      chk("R12 reset valid", int'(out_valid), 0);
      chk("R12 reset data", int'(out_data), 0);
      chk("R12 reset ovf", int'(out_ovf), 0);
   endtask

   task automatic test_sweep;
      int e, es;
      bit ov, ovs;
      for (int x = -(1 << (TW - 1)); x < (1 << (TW - 1)); x++) begin
         for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 2; s++) begin
               step(x, m, s[0]);
               ref_model(x, m, s[0], 1'b0, e, ov);
               ref_model(x, m, s[0], 1'b1, es, ovs);
               chk(s[0] ? {mode_tag(m), " R9"} : {mode_tag(m), " R10"}, int'(out_data), e);
               chk(s[0] ? "R9 ovf" : "R10 ovf", int'(out_ovf), int'(ov));
               chk("R11 data", int'(out_data_s), es);
               chk("R11 ovf", int'(out_ovf_s), int'(ovs));
               chk("R12 valid", int'(out_valid), 1);
            end
         end
      end
   endtask

   // exact halves: 12 -> 1.5, -12 -> -1.5, 20 -> 2.5 (N = 3)
   task automatic test_ties;
      int pos15 [8] = '{1, 2, 2, 1, 2, 1, 2, 1};
      int neg15 [8] = '{-2, -1, -1, -2, -2, -1, -2, -1};
      int pos25 [8] = '{2, 3, 3, 2, 3, 2, 2, 3};
      for (int m = 0; m < 8; m++) begin
         step(12, m, 1'b1);
         chk({mode_tag(m), " tie +1.5"}, int'(out_data), pos15[m] & OMASK);
         step(-12, m, 1'b1);
         chk({mode_tag(m), " tie -1.5"}, int'(out_data), neg15[m] & OMASK);
         step(20, m, 1'b1);
         chk({mode_tag(m), " tie +2.5"}, int'(out_data), pos25[m] & OMASK);
      end
   endtask

   task automatic test_range;
      step(511, 0, 1'b1);
      chk("R9 pos clamp", int'(out_data), 15);
      chk("R9 pos ovf", int'(out_ovf), 1);
      step(-512, 0, 1'b1);
      chk("R9 neg clamp", int'(out_data), 16);
      chk("R11 neg sym clamp", int'(out_data_s), 17);
      step(511, 0, 1'b0);
      chk("R10 wrap", int'(out_data), 31);
      chk("R10 wrap ovf", int'(out_ovf), 1);
      step(124, 2, 1'b1);
      chk("R9 carry clamp", int'(out_data), 15);
      chk("R9 carry ovf", int'(out_ovf), 1);
      step(124, 2, 1'b0);
      chk("R10 carry wrap", int'(out_data), 16);
      step(-128, 0, 1'b1);
      chk("R9 exact min no ovf", int'(out_ovf), 0);
      chk("R11 min clamp", int'(out_data_s), 17);
      chk("R11 min ovf", int'(out_ovf_s), 1);
      step(-128, 0, 1'b0);
      chk("R11 min wrap", int'(out_data_s), 16);
      chk("R11 min wrap ovf", int'(out_ovf_s), 1);
   endtask

   task automatic test_hold;
      step(40, 0, 1'b1);
      chk("R12 one-cycle valid", int'(out_valid), 1);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         in_data    = TW'(511 - 97 * k);
         round_mode = 3'(k);
         sat_en     = k[0];
         @(negedge clk);
         chk("R13 hold data", int'(out_data), 5);
         chk("R13 hold ovf", int'(out_ovf), 0);
         chk("R12 idle valid", int'(out_valid), 0);
      end
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_ties();
      test_range();
      test_hold();
      test_sweep();
      finish_run();
   end

endmodule